// File: doc/BRIEF.md
# Temperature threshold monitor

This block watches a stream of digital temperature readings from an on-die sensor. Each reading is an 8-bit unsigned code in half-degree steps, so code 0 is 0 °C and code 255 is 127.5 °C. A reading is taken only in a cycle where its valid strobe is high. Each reading is compared against three thresholds that are programmed independently. Every threshold has two alarms of its own: one for readings above it and one for readings below it.

The alarms are sticky and each has its own enable bit. Software acknowledges an alarm with a one-cycle clear pulse on that alarm's clear input. If the condition still holds, the next violating reading sets the alarm again. The block also keeps a high-water record and a low-water record of every accepted reading. Each record has its own reinitialise pulse. A single interrupt line combines all alarms that are both set and enabled.

Top module: `thermal_watch`

## Requirements
- R1: After reset, all over and under alarms read 0, the high-water record reads 0x00, the low-water record reads 0xFF, and irq is 0.
- R2: In the cycle after a valid reading, over alarm i is 1 if that reading was strictly greater than threshold i and over enable i was 1. Threshold i occupies bits [8i+7:8i] of thr_levels.
- R3: In the cycle after a valid reading, under alarm i is 1 if that reading was strictly less than threshold i and under enable i was 1.
- R4: A reading equal to threshold i sets neither alarm of threshold i.
- R5: A set alarm stays set through later readings that do not violate its threshold, until its clear input is pulsed.
- R6: While an alarm's enable bit is 0, no reading sets that alarm.
- R7: A clear pulse drives its alarm to 0 in the next cycle, and the clear wins over a violating reading in the same cycle. The next violating reading sets the alarm again.
- R8: The high-water record holds the largest valid reading accepted since reset or since its last reinitialise pulse.
- R9: The low-water record holds the smallest valid reading accepted since reset or since its last reinitialise pulse.
- R10: A pulse on clr_max loads 0x00 into the high-water record, and a pulse on clr_min loads 0xFF into the low-water record. A valid reading in the same cycle is not applied to the record being reinitialised.
- R11: irq is the OR of (over alarm i AND over enable i) and (under alarm i AND under enable i) over all i. It follows the enables combinationally, and dropping an enable does not clear the stored alarm.
- R12: The three thresholds act independently, and a reading with sample_valid at 0 changes no alarm and no record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_valid | input | 1 | Reading strobe; sample_code is used only while this is high |
| sample_code | input | 8 | Temperature code, 0.5 °C per step |
| thr_levels | input | 24 | Three thresholds; threshold i occupies bits [8i+7:8i] |
| en_over | input | 3 | Per-threshold enable for the above-threshold alarms |
| en_under | input | 3 | Per-threshold enable for the below-threshold alarms |
| clr_over | input | 3 | Per-threshold clear pulse for the above-threshold alarms |
| clr_under | input | 3 | Per-threshold clear pulse for the below-threshold alarms |
| clr_max | input | 1 | Reinitialise pulse for the high-water record |
| clr_min | input | 1 | Reinitialise pulse for the low-water record |
| over_flags | output | 3 | Sticky above-threshold alarms |
| under_flags | output | 3 | Sticky below-threshold alarms |
| peak_hi | output | 8 | High-water record |
| peak_lo | output | 8 | Low-water record |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest case to reach from the ports is a collision: a clear pulse or a record reinitialise in the same cycle as a reading that would set the same alarm or replace the same record. Ordinary traffic almost never lines these up. Directed steps drive both inputs on the same edge, then send a second, unclear reading to show that the alarm sets again. An exhaustive sweep of all 256 codes is run against three threshold sets, which include the extremes 0x00 and 0xFF. The sweep clears all alarms before each reading, so every reading is judged on its own, and it hits the equality point of every threshold.

// File: rtl/thermal_watch_pkg.sv
package thermal_watch_pkg;

    // Where a reading falls relative to one threshold
    typedef enum logic [1:0] {
        REL_BELOW = 2'd0,
        REL_EQUAL = 2'd1,
        REL_ABOVE = 2'd2
    } rel_t;

    localparam int TEMP_W_DEFAULT  = 8;
    localparam int NUM_THR_DEFAULT = 3;

endpackage

// File: rtl/thermal_cmp_lane.sv
module thermal_cmp_lane
    import thermal_watch_pkg::*;
#(
    parameter int TEMP_W = TEMP_W_DEFAULT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_valid,
    input  logic [TEMP_W-1:0] sample_code,
    input  logic [TEMP_W-1:0] thr_level,
    input  logic              en_over,
    input  logic              en_under,
    input  logic              clr_over,
    input  logic              clr_under,
    output logic              over_flag,
    output logic              under_flag
);

    typedef struct packed {
        logic over;
        logic under;
    } lane_state_t;

    lane_state_t st_d, st_q;
    rel_t        rel;

    always_comb begin
        if (sample_code > thr_level)      rel = REL_ABOVE;
        else if (sample_code < thr_level) rel = REL_BELOW;
        else                              rel = REL_EQUAL;
    end

    always_comb begin
        st_d = st_q;
        if (sample_valid && en_over && rel == REL_ABOVE)
            st_d.over = 1'b1;
        if (sample_valid && en_under && rel == REL_BELOW)
            st_d.under = 1'b1;
        // clear takes precedence over a same-cycle set
        if (clr_over)
            st_d.over = 1'b0;
        if (clr_under)
            st_d.under = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign over_flag  = st_q.over;
    assign under_flag = st_q.under;

    assert_over_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.over) |-> $past(sample_valid && en_over && !clr_over
                                   && (sample_code > thr_level)));

    assert_under_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.under) |-> $past(sample_valid && en_under && !clr_under
                                    && (sample_code < thr_level)));

    assert_over_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.over && !clr_over) |=> st_q.over);

    assert_under_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.under && !clr_under) |=> st_q.under);

    assert_over_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_over |=> !st_q.over);

    assert_under_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_under |=> !st_q.under);

endmodule

// File: rtl/thermal_peak_track.sv
module thermal_peak_track
    import thermal_watch_pkg::*;
#(
    parameter int TEMP_W = TEMP_W_DEFAULT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_valid,
    input  logic [TEMP_W-1:0] sample_code,
    input  logic              clr_max,
    input  logic              clr_min,
    output logic [TEMP_W-1:0] peak_hi,
    output logic [TEMP_W-1:0] peak_lo
);

    localparam logic [TEMP_W-1:0] HI_INIT = '0;
    localparam logic [TEMP_W-1:0] LO_INIT = '1;

    typedef struct packed {
        logic [TEMP_W-1:0] hi;
        logic [TEMP_W-1:0] lo;
    } peak_state_t;

    peak_state_t pk_d, pk_q;

    always_comb begin
        pk_d = pk_q;
        if (clr_max)
            pk_d.hi = HI_INIT;
        else if (sample_valid && sample_code > pk_q.hi)
            pk_d.hi = sample_code;
        if (clr_min)
            pk_d.lo = LO_INIT;
        else if (sample_valid && sample_code < pk_q.lo)
            pk_d.lo = sample_code;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pk_q.hi <= HI_INIT;
            pk_q.lo <= LO_INIT;
        end else begin
            pk_q <= pk_d;
        end
    end

    assign peak_hi = pk_q.hi;
    assign peak_lo = pk_q.lo;

    assert_hi_monotonic_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_max |=> pk_q.hi >= $past(pk_q.hi));

    assert_hi_covers_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && !clr_max) |=> pk_q.hi >= $past(sample_code));

    assert_lo_monotonic_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_min |=> pk_q.lo <= $past(pk_q.lo));

    assert_lo_covers_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && !clr_min) |=> pk_q.lo <= $past(sample_code));

    assert_hi_reinit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_max |=> pk_q.hi == HI_INIT);

    assert_lo_reinit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_min |=> pk_q.lo == LO_INIT);

    assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_valid && !clr_max && !clr_min) |=> $stable(pk_q));

endmodule

// File: rtl/thermal_irq_merge.sv
module thermal_irq_merge
    import thermal_watch_pkg::*;
#(
    parameter int NUM_THR = NUM_THR_DEFAULT
) (
    input  logic [NUM_THR-1:0] over_flags,
    input  logic [NUM_THR-1:0] under_flags,
    input  logic [NUM_THR-1:0] en_over,
    input  logic [NUM_THR-1:0] en_under,
    output logic               irq
);

    logic [NUM_THR-1:0] lane_active;

    for (genvar gi = 0; gi < NUM_THR; gi++) begin : g_active
        assign lane_active[gi] = (over_flags[gi] & en_over[gi])
                               | (under_flags[gi] & en_under[gi]);
    end

    assign irq = |lane_active;

endmodule

// File: rtl/thermal_watch.sv
module thermal_watch
    import thermal_watch_pkg::*;
#(
    parameter int TEMP_W    = TEMP_W_DEFAULT,
    parameter int NUM_THR   = NUM_THR_DEFAULT,
    localparam int THR_BUS_W = TEMP_W * NUM_THR
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sample_valid,
    input  logic [TEMP_W-1:0]    sample_code,
    input  logic [THR_BUS_W-1:0] thr_levels,
    input  logic [NUM_THR-1:0]   en_over,
    input  logic [NUM_THR-1:0]   en_under,
    input  logic [NUM_THR-1:0]   clr_over,
    input  logic [NUM_THR-1:0]   clr_under,
    input  logic                 clr_max,
    input  logic                 clr_min,
    output logic [NUM_THR-1:0]   over_flags,
    output logic [NUM_THR-1:0]   under_flags,
    output logic [TEMP_W-1:0]    peak_hi,
    output logic [TEMP_W-1:0]    peak_lo,
    output logic                 irq
);

    for (genvar gi = 0; gi < NUM_THR; gi++) begin : g_lane
        thermal_cmp_lane #(
            .TEMP_W (TEMP_W)
        ) u_lane (
            .clk          (clk),
            .rst_n        (rst_n),
            .sample_valid (sample_valid),
            .sample_code  (sample_code),
            .thr_level    (thr_levels[gi*TEMP_W +: TEMP_W]),
            .en_over      (en_over[gi]),
            .en_under     (en_under[gi]),
            .clr_over     (clr_over[gi]),
            .clr_under    (clr_under[gi]),
            .over_flag    (over_flags[gi]),
            .under_flag   (under_flags[gi])
        );
    end

    thermal_peak_track #(
        .TEMP_W (TEMP_W)
    ) u_peak (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_valid (sample_valid),
        .sample_code  (sample_code),
        .clr_max      (clr_max),
        .clr_min      (clr_min),
        .peak_hi      (peak_hi),
        .peak_lo      (peak_lo)
    );

    thermal_irq_merge #(
        .NUM_THR (NUM_THR)
    ) u_irq (
        .over_flags  (over_flags),
        .under_flags (under_flags),
        .en_over     (en_over),
        .en_under    (en_under),
        .irq         (irq)
    );

    // an interrupt always has a stored alarm behind it
    assert_irq_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((over_flags != '0) || (under_flags != '0)));

    // with every enable off, the interrupt line stays low
    assert_irq_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((en_over == '0) && (en_under == '0)) |-> !irq);

endmodule

// File: tb/thermal_watch_test.sv
module thermal_watch_test;

    localparam int W = 8;
    localparam int N = 3;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           sample_valid;
    logic [W-1:0]   sample_code;
    logic [N*W-1:0] thr_levels;
    logic [N-1:0]   en_over, en_under, clr_over, clr_under;
    logic           clr_max, clr_min;
    logic [N-1:0]   over_flags, under_flags;
    logic [W-1:0]   peak_hi, peak_lo;
    logic           irq;

    always #10 clk = ~clk;

    thermal_watch #(.TEMP_W(W), .NUM_THR(N)) uut (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
        .sample_code(sample_code), .thr_levels(thr_levels),
        .en_over(en_over), .en_under(en_under),
        .clr_over(clr_over), .clr_under(clr_under),
        .clr_max(clr_max), .clr_min(clr_min),
        .over_flags(over_flags), .under_flags(under_flags),
        .peak_hi(peak_hi), .peak_lo(peak_lo), .irq(irq)
    );

    int checks = 0;
    int errors = 0;

    // bench-side expectations
    logic [N-1:0] m_over, m_under;
    logic [W-1:0] m_hi, m_lo;

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int thr_of(int i);
        return int'(thr_levels[i*W +: W]);
    endfunction

    function automatic int exp_irq();
        return int'(|((m_over & en_over) | (m_under & en_under)));
    endfunction

    // entered at a falling edge; leaves at the next falling edge
    task automatic step(bit v, int code, logic [N-1:0] co, logic [N-1:0] cu,
                        bit cmx, bit cmn);
        sample_valid = v;
        sample_code  = code[W-1:0];
        clr_over     = co;
        clr_under    = cu;
        clr_max      = cmx;
        clr_min      = cmn;
        for (int i = 0; i < N; i++) begin
            if (co[i])                                    m_over[i] = 1'b0;
            else if (v && en_over[i] && code > thr_of(i))  m_over[i] = 1'b1;
            if (cu[i])                                    m_under[i] = 1'b0;
            else if (v && en_under[i] && code < thr_of(i)) m_under[i] = 1'b1;
        end
        if (cmx)                        m_hi = '0;
        else if (v && code > int'(m_hi)) m_hi = code[W-1:0];
        if (cmn)                        m_lo = '1;
        else if (v && code < int'(m_lo)) m_lo = code[W-1:0];
        @(posedge clk);
        @(negedge clk);
        sample_valid = 1'b0;
        clr_over = '0; clr_under = '0; clr_max = 1'b0; clr_min = 1'b0;
    endtask

    task automatic check_all();
        check("R2 over alarms", int'(over_flags), int'(m_over));
        check("R3 under alarms", int'(under_flags), int'(m_under));
        check("R8 high-water", int'(peak_hi), int'(m_hi));
        check("R9 low-water", int'(peak_lo), int'(m_lo));
        check("R11 irq", int'(irq), exp_irq());
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        sample_valid = 1'b0; sample_code = '0;
        thr_levels = {8'd200, 8'd100, 8'd50};
        en_over = '1; en_under = '1;
        clr_over = '0; clr_under = '0; clr_max = 1'b0; clr_min = 1'b0;
        m_over = '0; m_under = '0; m_hi = '0; m_lo = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 over after reset", int'(over_flags), 0);
        check("R1 under after reset", int'(under_flags), 0);
        check("R1 high-water after reset", int'(peak_hi), 0);
        check("R1 low-water after reset", int'(peak_lo), 255);
        check("R1 irq after reset", int'(irq), 0);

        // exhaustive sweep, three threshold sets, lanes distinct (R12)
        for (int cfg = 0; cfg < 3; cfg++) begin
            case (cfg)
                0:       thr_levels = {8'd200, 8'd100, 8'd50};
                1:       thr_levels = {8'd255, 8'd128, 8'd0};
                default: thr_levels = {8'd1, 8'd254, 8'd127};
            endcase
            for (int code = 0; code < 256; code++) begin
                step(1'b0, 0, '1, '1, 1'b0, 1'b0);
                step(1'b1, code, '0, '0, 1'b0, 1'b0);
                check_all();
                for (int i = 0; i < N; i++)
                    if (code == thr_of(i))
                        check("R4 equal sets nothing",
                              int'(over_flags[i] | under_flags[i]), 0);
            end
        end

        // R12 invalid readings ignored
        step(1'b0, 0, '1, '1, 1'b1, 1'b1);
        thr_levels = {8'd100, 8'd100, 8'd100};
        step(1'b0, 200, '0, '0, 1'b0, 1'b0);
        check("R12 invalid leaves high-water", int'(peak_hi), 0);
        check("R12 invalid leaves low-water", int'(peak_lo), 255);
        check("R12 invalid leaves alarms", int'(over_flags | under_flags), 0);

        // R10 reinitialise collides with a valid reading
        step(1'b1, 150, '0, '0, 1'b0, 1'b0);
        step(1'b1, 77, '0, '0, 1'b1, 1'b1);
        check("R10 clr_max wins", int'(peak_hi), 0);
        check("R10 clr_min wins", int'(peak_lo), 255);
        step(1'b1, 77, '0, '0, 1'b0, 1'b0);
        check("R10 high-water after reinit", int'(peak_hi), 77);
        check("R10 low-water after reinit", int'(peak_lo), 77);

        // R5 stickiness
        step(1'b0, 0, '1, '1, 1'b0, 1'b0);
        step(1'b1, 150, '0, '0, 1'b0, 1'b0);
        step(1'b1, 100, '0, '0, 1'b0, 1'b0);
        check("R5 over stays set", int'(over_flags), 7);
        step(1'b1, 50, '0, '0, 1'b0, 1'b0);
        check("R5 over still set with under", int'(over_flags), 7);
        check("R5 under now set", int'(under_flags), 7);
        check_all();

        // R7 clear versus simultaneous violating reading
        step(1'b1, 150, 3'b001, '0, 1'b0, 1'b0);
        check("R7 clear wins on lane 0", int'(over_flags), 6);
        step(1'b1, 150, '0, '0, 1'b0, 1'b0);
        check("R7 sets again", int'(over_flags), 7);
        step(1'b0, 0, '0, 3'b010, 1'b0, 1'b0);
        check("R7 under lane 1 cleared", int'(under_flags), 5);
        check_all();

        // R6 enable gates setting
        step(1'b0, 0, '1, '1, 1'b0, 1'b0);
        en_over = 3'b000; en_under = 3'b101;
        step(1'b1, 220, '0, '0, 1'b0, 1'b0);
        check("R6 over gated", int'(over_flags), 0);
        step(1'b1, 10, '0, '0, 1'b0, 1'b0);
        check("R6 under lane 1 gated", int'(under_flags), 5);
        check_all();

        // R11 irq follows enables without touching flags
        en_over = '1; en_under = '1;
        step(1'b1, 220, '0, '0, 1'b0, 1'b0);
        check("R11 irq with alarms", int'(irq), 1);
        en_over = '0; en_under = '0;
        #1;
        check("R11 irq masked", int'(irq), 0);
        check("R11 flags kept when masked", int'(over_flags), 7);
        en_under = 3'b100;
        #1;
        check("R11 irq via one under enable", int'(irq), 1);
        en_over = '1; en_under = '1;
        check_all();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule